// File: doc/BRIEF.md
# Column-Compression Unsigned Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. An AND array forms one partial-product bit for each pair of operand bits. Each bit column of this matrix is then reduced by population counters, each of which takes up to seven bits of equal weight and turns them into a 3-bit count. Bit 0 of the count stays in its column, bit 1 moves one column up and bit 2 moves two columns up. Reduction stages repeat until no column holds more than two bits. A ripple carry-propagate adder then sums the two remaining rows.

The parameter `USE_COUNTERS` picks the reduction variant. When it is 1, columns are split into groups of up to seven bits, each group going to one counter (7, 6, 5, 4 or 3 inputs). When it is 0, columns are split into groups of three bits (full adders), and a leftover pair goes to a half adder. This costs more reduction stages, but each cell is smaller. The tree itself is combinational. Registers sit only at its inputs and at its outputs.

A two-state machine tracks whether the operand registers hold a pending operation. State `ST_IDLE` moves to `ST_LOADED` when `in_valid` is high (transition *capture*). `ST_LOADED` stays in `ST_LOADED` when `in_valid` is high again (transition *stream*), and returns to `ST_IDLE` otherwise (transition *drain*). In `ST_IDLE` the machine stays put while `in_valid` is low (transition *hold*). Operands are captured at the clock edge where `in_valid` is high. The product and `out_valid` are registered at the following edge.

Top module: `colcount_mult`

## Requirements
- R1: The partial-product bit for `mcand[j]` and `mplier[i]` is their AND and carries weight 2^(i+j). A pair of one-hot operands with bits j and i set gives a product with only bit i+j set.
- R2: When `out_valid` is high, `product` equals the unsigned product of the `mcand` and `mplier` values that were present with `in_valid` high two rising edges earlier, zero-extended to `2*WIDTH` bits.
- R3: `out_valid` is high after a rising edge exactly when `in_valid` was high at the rising edge before it. An operation presented at edge k therefore shows `out_valid` high after edge k+1, for one cycle unless it is followed by another operation.
- R4: While `out_valid` is low, `product` keeps its last value. Operand changes made while `in_valid` is low have no effect on `product`.
- R5: A low `rst_n` clears `out_valid` and `product` to 0 and returns the state machine to `ST_IDLE`. A pending operation is discarded.
- R6: With `USE_COUNTERS` = 1, each column taller than two bits is split into groups of up to seven bits. Each group feeds one counter, whose count bits 0, 1 and 2 go to the same column, the next column and the column two places up. The resulting product meets R2 for every operand pair.
- R7: With `USE_COUNTERS` = 0, columns are reduced only with full adders (3 inputs) and half adders (2 inputs), and the product meets R2 for every operand pair.
- R8: Operations presented on consecutive cycles are all accepted. Their products appear on consecutive cycles in the same order.
- R9: Zero operands give a zero product. All-ones operands give (2^WIDTH-1)^2, the largest product.
- R10: At widths larger than 6, the tree produces the correct product. The larger width brings more columns, more reduction stages and taller columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid and are captured at this edge |
| mcand | input | WIDTH | Unsigned multiplicand |
| mplier | input | WIDTH | Unsigned multiplier |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 2*WIDTH | Registered unsigned product |

## Verification
The bench builds three copies of the block. The first has WIDTH 6 with counters, and the second has WIDTH 6 with full and half adders only. Both are driven with all 4096 operand pairs, so every column pattern of both reduction variants is exercised. The third copy has WIDTH 9 with counters and receives random and extreme operands. Its taller columns make seven-input counters and extra reduction stages occur, which the 6-bit case cannot show. Idle bubbles between operations, a reset that lands on a pending operation, and back-to-back streams test the hold, latency and ordering rules.

// File: rtl/mult_pkg.sv
package mult_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } mult_state_e;

    // Population count of up to seven bits, returned as a 3-bit count.
    function automatic logic [2:0] count_ones7(input logic [6:0] v);
        logic [2:0] r;
        r = 3'd0;
        for (int j = 0; j < 7; j++) begin
            r = r + {2'b00, v[j]};
        end
        return r;
    endfunction

    // Number of partial-product bits in column c of a w-by-w array.
    function automatic int pp_height(input int c, input int w);
        int lo;
        int hi;
        lo = (c - w + 1 > 0) ? (c - w + 1) : 0;
        hi = (c < w - 1) ? c : (w - 1);
        return (hi >= lo) ? (hi - lo + 1) : 0;
    endfunction

    // Lowest multiplier-bit index contributing to column c.
    function automatic int pp_low(input int c, input int w);
        return (c - w + 1 > 0) ? (c - w + 1) : 0;
    endfunction

endpackage

// File: rtl/mult_pp_array.sv
module mult_pp_array
    import mult_pkg::*;
#(
    parameter int WIDTH = 6,
    parameter int COLS  = 2 * WIDTH,
    parameter int MAXH  = WIDTH + 2
) (
    input  logic [WIDTH-1:0]           op_a,
    input  logic [WIDTH-1:0]           op_b,
    output logic [COLS-1:0][MAXH-1:0]  pp_cols
);

    // Column c slot k holds op_a[c-i] & op_b[i], with i = low(c) + k.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam int HC = pp_height(c, WIDTH);
        localparam int LO = pp_low(c, WIDTH);
        for (genvar k = 0; k < MAXH; k++) begin : g_slot
            if (k < HC) begin : g_bit
                localparam int IB = LO + k;
                localparam int JA = c - IB;
                assign pp_cols[c][k] = op_a[JA] & op_b[IB];
            end else begin : g_zero
                assign pp_cols[c][k] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/mult_compress_tree.sv
module mult_compress_tree
    import mult_pkg::*;
#(
    parameter int WIDTH        = 6,
    parameter int COLS         = 2 * WIDTH,
    parameter int MAXH         = WIDTH + 2,
    parameter int STAGES       = WIDTH,
    parameter bit USE_COUNTERS = 1'b1
) (
    input  logic [COLS-1:0][MAXH-1:0] pp_cols,
    output logic [COLS-1:0]           row_a,
    output logic [COLS-1:0]           row_b
);

    localparam int GS = USE_COUNTERS ? 7 : 3;

    logic [COLS-1:0][MAXH-1:0] cur;
    logic [COLS-1:0][MAXH-1:0] nxt;
    int                        cur_h [COLS];
    int                        nxt_h [COLS];
    logic [6:0]                grp;
    logic [2:0]                cnt;
    int                        g;

    always_comb begin
        cur = pp_cols;
        nxt = '0;
        grp = '0;
        cnt = '0;
        g   = 0;
        for (int c = 0; c < COLS; c++) begin
            cur_h[c] = pp_height(c, WIDTH);
            nxt_h[c] = 0;
        end
        for (int s = 0; s < STAGES; s++) begin
            nxt = '0;
            for (int c = 0; c < COLS; c++) begin
                nxt_h[c] = 0;
            end
            for (int c = 0; c < COLS; c++) begin
                if (cur_h[c] <= 2) begin
                    // Short column: bits pass to the next stage untouched.
                    for (int k = 0; k < 2; k++) begin
                        if (k < cur_h[c] && nxt_h[c] < MAXH) begin
                            nxt[c][nxt_h[c]] = cur[c][k];
                            nxt_h[c] = nxt_h[c] + 1;
                        end
                    end
                end else begin
                    for (int k = 0; k < MAXH; k += GS) begin
                        g = cur_h[c] - k;
                        if (g > GS) begin
                            g = GS;
                        end
                        if (g == 1) begin
                            if (nxt_h[c] < MAXH) begin
                                nxt[c][nxt_h[c]] = cur[c][k];
                                nxt_h[c] = nxt_h[c] + 1;
                            end
                        end else if (g >= 2) begin
                            grp = '0;
                            for (int j = 0; j < 7; j++) begin
                                if (j < g && k + j < MAXH) begin
                                    grp[j] = cur[c][k+j];
                                end
                            end
                            cnt = count_ones7(grp);
                            // Count bit 0 stays, bit 1 up one, bit 2 up two.
                            if (nxt_h[c] < MAXH) begin
                                nxt[c][nxt_h[c]] = cnt[0];
                                nxt_h[c] = nxt_h[c] + 1;
                            end
                            if (c + 1 < COLS) begin
                                if (nxt_h[c+1] < MAXH) begin
                                    nxt[c+1][nxt_h[c+1]] = cnt[1];
                                    nxt_h[c+1] = nxt_h[c+1] + 1;
                                end
                            end
                            if (g >= 4 && c + 2 < COLS) begin
                                if (nxt_h[c+2] < MAXH) begin
                                    nxt[c+2][nxt_h[c+2]] = cnt[2];
                                    nxt_h[c+2] = nxt_h[c+2] + 1;
                                end
                            end
                        end
                    end
                end
            end
            cur = nxt;
            for (int c = 0; c < COLS; c++) begin
                cur_h[c] = nxt_h[c];
            end
        end
        for (int c = 0; c < COLS; c++) begin
            row_a[c] = (cur_h[c] > 0) ? cur[c][0] : 1'b0;
            row_b[c] = (cur_h[c] > 1) ? cur[c][1] : 1'b0;
        end
    end

endmodule

// File: rtl/mult_cpa.sv
module mult_cpa #(
    parameter int COLS = 12
) (
    input  logic [COLS-1:0] row_a,
    input  logic [COLS-1:0] row_b,
    output logic [COLS-1:0] sum
);

    logic [COLS:0] carry;

    assign carry[0] = 1'b0;

    for (genvar k = 0; k < COLS; k++) begin : g_bit
        assign sum[k]     = row_a[k] ^ row_b[k] ^ carry[k];
        assign carry[k+1] = (row_a[k] & row_b[k]) | (carry[k] & (row_a[k] ^ row_b[k]));
    end

endmodule

// File: rtl/colcount_mult.sv
module colcount_mult
    import mult_pkg::*;
#(
    parameter int WIDTH        = 6,
    parameter bit USE_COUNTERS = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WIDTH-1:0]     mcand,
    input  logic [WIDTH-1:0]     mplier,
    output logic                 out_valid,
    output logic [2*WIDTH-1:0]   product
);

    localparam int COLS   = 2 * WIDTH;
    localparam int MAXH   = WIDTH + 2;
    localparam int STAGES = WIDTH;

    mult_state_e               state_q;
    mult_state_e               state_d;
    logic                      cap_en;
    logic                      res_en;
    logic [WIDTH-1:0]          op_a_q;
    logic [WIDTH-1:0]          op_b_q;
    logic [COLS-1:0][MAXH-1:0] pp_cols;
    logic [COLS-1:0]           row_a;
    logic [COLS-1:0]           row_b;
    logic [COLS-1:0]           sum;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and register enables.
    always_comb begin
        state_d = state_q;
        cap_en  = in_valid;
        res_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = ST_LOADED;
                end
            end
            ST_LOADED: begin
                res_en = 1'b1;
                if (!in_valid) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a_q <= '0;
            op_b_q <= '0;
        end else if (cap_en) begin
            op_a_q <= mcand;
            op_b_q <= mplier;
        end
    end

    mult_pp_array #(
        .WIDTH (WIDTH),
        .COLS  (COLS),
        .MAXH  (MAXH)
    ) u_pp (
        .op_a    (op_a_q),
        .op_b    (op_b_q),
        .pp_cols (pp_cols)
    );

    mult_compress_tree #(
        .WIDTH        (WIDTH),
        .COLS         (COLS),
        .MAXH         (MAXH),
        .STAGES       (STAGES),
        .USE_COUNTERS (USE_COUNTERS)
    ) u_tree (
        .pp_cols (pp_cols),
        .row_a   (row_a),
        .row_b   (row_b)
    );

    mult_cpa #(
        .COLS (COLS)
    ) u_cpa (
        .row_a (row_a),
        .row_b (row_b),
        .sum   (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            product   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= res_en;
            if (res_en) begin
                product <= sum;
            end
        end
    end

endmodule

// File: rtl/colcount_mult_chk.sv
module colcount_mult_chk #(
    parameter int WIDTH = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [WIDTH-1:0]     mcand,
    input logic [WIDTH-1:0]     mplier,
    input logic                 out_valid,
    input logic [2*WIDTH-1:0]   product
);

    // R2
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> product ==
            ({{WIDTH{1'b0}}, $past(mcand, 2)} * {{WIDTH{1'b0}}, $past(mplier, 2)}));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R3
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(product));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0));

endmodule

bind colcount_mult colcount_mult_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/colcount_mult_tb.sv
module colcount_mult_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NTAB = 8;
    localparam logic [5:0] TAB_A [NTAB] = '{6'd1, 6'd2, 6'd4, 6'd32, 6'd8, 6'd1, 6'd32, 6'd16};
    localparam logic [5:0] TAB_B [NTAB] = '{6'd1, 6'd8, 6'd16, 6'd32, 6'd1, 6'd32, 6'd1, 6'd4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v_in = 1'b0;
    logic [5:0]  a6 = '0;
    logic [5:0]  b6 = '0;
    logic [8:0]  a9 = '0;
    logic [8:0]  b9 = '0;
    logic        ov_c, ov_f, ov_w;
    logic [11:0] p_c, p_f;
    logic [17:0] p_w;

    int checks = 0;
    int errors = 0;

    logic       h_v [2];
    logic [5:0] h_a6 [2];
    logic [5:0] h_b6 [2];
    logic [8:0] h_a9 [2];
    logic [8:0] h_b9 [2];
    string      h_tag [2];
    logic [11:0] last6_c, last6_f;
    logic [17:0] last9;

    always #(CLK_PERIOD/2) clk = ~clk;

    colcount_mult #(.WIDTH(6), .USE_COUNTERS(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(v_in), .mcand(a6), .mplier(b6),
        .out_valid(ov_c), .product(p_c));

    colcount_mult #(.WIDTH(6), .USE_COUNTERS(1'b0)) u_dut_fa (
        .clk(clk), .rst_n(rst_n), .in_valid(v_in), .mcand(a6), .mplier(b6),
        .out_valid(ov_f), .product(p_f));

    colcount_mult #(.WIDTH(9), .USE_COUNTERS(1'b1)) u_dut_w9 (
        .clk(clk), .rst_n(rst_n), .in_valid(v_in), .mcand(a9), .mplier(b9),
        .out_valid(ov_w), .product(p_w));

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int k = 0; k < 2; k++) begin
            h_v[k] = 1'b0; h_a6[k] = '0; h_b6[k] = '0;
            h_a9[k] = '0; h_b9[k] = '0; h_tag[k] = "R4";
        end
        last6_c = '0; last6_f = '0; last9 = '0;
    endtask

    // One cycle: check the entry issued two cycles ago, then drive the new one.
    task automatic step(input logic v, input logic [5:0] a, input logic [5:0] b,
                        input logic [8:0] c, input logic [8:0] d, input string tag);
        logic [11:0] e6;
        logic [17:0] e9;
        @(negedge clk);
        if (h_v[1]) begin
            e6 = 12'(h_a6[1]) * 12'(h_b6[1]);
            e9 = 18'(h_a9[1]) * 18'(h_b9[1]);
            chk(ov_c == 1'b1 && ov_f == 1'b1 && ov_w == 1'b1, "R3", "out_valid set",
                {ov_c, ov_f, ov_w}, 7);
            chk(p_c == e6, h_tag[1], "counter product", p_c, e6);
            chk(p_f == e6, "R7", "adder product", p_f, e6);
            chk(p_w == e9, "R10", "wide product", p_w, e9);
            last6_c = e6; last6_f = e6; last9 = e9;
        end else begin
            chk(ov_c == 1'b0 && ov_f == 1'b0 && ov_w == 1'b0, "R3", "out_valid clear",
                {ov_c, ov_f, ov_w}, 0);
            chk(p_c == last6_c && p_f == last6_f && p_w == last9, "R4", "held product",
                p_c, last6_c);
        end
        h_v[1] = h_v[0]; h_a6[1] = h_a6[0]; h_b6[1] = h_b6[0];
        h_a9[1] = h_a9[0]; h_b9[1] = h_b9[0]; h_tag[1] = h_tag[0];
        h_v[0] = v; h_a6[0] = a; h_b6[0] = b; h_a9[0] = c; h_b9[0] = d; h_tag[0] = tag;
        v_in = v; a6 = a; b6 = b; a9 = c; b9 = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_hist();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5: reset state
        chk(!ov_c && !ov_f && !ov_w && p_c == 0 && p_f == 0 && p_w == 0, "R5",
            "reset outputs", p_c, 0);
        rst_n = 1'b1;

        // R1: one-hot operands from the table.
        for (int t = 0; t < NTAB; t++) begin
            step(1'b1, TAB_A[t], TAB_B[t], 9'(TAB_A[t]), 9'(TAB_B[t]), "R1");
        end
        step(1'b0, 6'd0, 6'd0, 9'd0, 9'd0, "R4");
        step(1'b0, 6'd0, 6'd0, 9'd0, 9'd0, "R4");

        // R9: extremes.
        step(1'b1, 6'd0, 6'd63, 9'd0, 9'd511, "R9");
        step(1'b1, 6'd63, 6'd63, 9'd511, 9'd511, "R9");
        step(1'b1, 6'd63, 6'd0, 9'd511, 9'd0, "R9");
        step(1'b0, 6'd0, 6'd0, 9'd0, 9'd0, "R4");

        // R4: operand changes with in_valid low are ignored.
        step(1'b0, 6'd17, 6'd29, 9'd300, 9'd77, "R4");
        step(1'b0, 6'd41, 6'd5, 9'd123, 9'd456, "R4");
        step(1'b0, 6'd0, 6'd0, 9'd0, 9'd0, "R4");

        // R2/R6/R7/R8: exhaustive back-to-back stream at width 6, random width 9 (R10).
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                step(1'b1, 6'(i), 6'(j), 9'($urandom), 9'($urandom), "R2/R6/R8");
            end
        end
        // Bubble pattern: alternate valid and idle.
        for (int i = 0; i < 20; i++) begin
            step(i[0] == 1'b0, 6'($urandom), 6'($urandom), 9'($urandom), 9'($urandom),
                 i[0] == 1'b0 ? "R2" : "R4");
        end
        step(1'b0, 6'd0, 6'd0, 9'd0, 9'd0, "R4");
        step(1'b0, 6'd0, 6'd0, 9'd0, 9'd0, "R4");

        // R5: reset lands on a pending operation.
        step(1'b1, 6'd45, 6'd50, 9'd400, 9'd401, "R5");
        @(negedge clk);
        v_in = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!ov_c && !ov_f && !ov_w, "R5", "valid cleared by reset", ov_c, 0);
        chk(p_c == 0 && p_f == 0 && p_w == 0, "R5", "product cleared by reset", p_c, 0);
        rst_n = 1'b1;
        clear_hist();
        step(1'b0, 6'd0, 6'd0, 9'd0, 9'd0, "R5");
        step(1'b0, 6'd0, 6'd0, 9'd0, 9'd0, "R5");
        step(1'b0, 6'd0, 6'd0, 9'd0, 9'd0, "R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule